// File: doc/BRIEF.md
# Dual Micro-TLB Address Translator

This block turns two virtual page numbers into physical page numbers in the same cycle. One request stream comes from instruction fetch and the other from data access. Each stream has its own small, fully associative micro-TLB. A shared, larger joint TLB backs both of them. When a micro-TLB hit occurs, the physical page number appears one cycle after the request is accepted. When a micro-TLB misses, the requesting side stalls and searches the joint TLB. The entry found there is copied into the micro-TLB that missed, replacing its least recently used entry.

The joint TLB has a single search port. When both sides miss together, the data side is served first and the instruction side waits one more cycle. If the joint TLB also misses, the response carries a fault flag and nothing is refilled. Software can read, write and probe the joint TLB through a command port. Every joint-TLB write empties both micro-TLBs, so no stale copy survives.

Top module: `dual_tlb`

## Requirements
- R1: After reset, both `*_req_ready` outputs are high, all response valids are low, and every joint-TLB entry is invalid, so a probe reports no match.
- R2: The instruction and data sides translate independently. Two simultaneous micro-TLB hits both respond one cycle after acceptance, and a refill on one side does not fill the other side's micro-TLB.
- R3: A request is accepted on a clock edge where valid and ready are both high. On a micro-TLB hit, `*_rsp_valid` is high in the next cycle with the stored page number and fault 0.
- R4: A refill goes to an invalid micro-TLB slot if one exists. Otherwise it replaces the entry that has gone longest without a hit or refill. Both hits and refills count as use.
- R5: A micro-TLB miss answers two cycles after acceptance, which is one extra cycle compared with a hit. A later request for the same page then hits.
- R6: When both sides miss in the same cycle, the data side answers two cycles after acceptance and the instruction side answers three cycles after acceptance.
- R7: `sw_op` is encoded as 0 for read, 1 for write, 2 for probe and 3 for no action. A read or probe answers with `sw_rsp_valid` in the next cycle. A write gives no response and takes effect from the next cycle; `sw_entry_valid` sets the valid bit of the written entry. Code 3 produces no response.
- R8: A probe returns the lowest index of a valid entry whose page number matches, with `sw_rsp_nomatch` low. When no entry matches, `sw_rsp_nomatch` is high and the index is 0.
- R9: A joint-TLB write invalidates every entry of both micro-TLBs.
- R10: A joint-TLB miss answers with fault 1 and page number 0 at miss latency, and performs no refill, so a repeated request misses again.
- R11: `*_req_ready` is low during every cycle in which that side waits for the joint TLB, and it goes high again in the cycle its response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_req_valid | input | 1 | Instruction request valid |
| i_req_vpn | input | VPN_W | Instruction virtual page number |
| i_req_ready | output | 1 | Instruction side can accept a request |
| i_rsp_valid | output | 1 | Instruction response valid |
| i_rsp_pfn | output | PFN_W | Instruction physical page number |
| i_rsp_fault | output | 1 | Instruction translation not found |
| d_req_valid | input | 1 | Data request valid |
| d_req_vpn | input | VPN_W | Data virtual page number |
| d_req_ready | output | 1 | Data side can accept a request |
| d_rsp_valid | output | 1 | Data response valid |
| d_rsp_pfn | output | PFN_W | Data physical page number |
| d_rsp_fault | output | 1 | Data translation not found |
| sw_valid | input | 1 | Software command valid |
| sw_op | input | 2 | Command: 0 read, 1 write, 2 probe, 3 none |
| sw_index | input | log2(JOINT_N) | Joint-TLB index for read and write |
| sw_vpn | input | VPN_W | Page number for write and probe |
| sw_pfn | input | PFN_W | Physical page number for write |
| sw_entry_valid | input | 1 | Valid bit written with the entry |
| sw_rsp_valid | output | 1 | Software response valid |
| sw_rsp_entry_valid | output | 1 | Read: entry valid; probe: found |
| sw_rsp_index | output | log2(JOINT_N) | Index read or index found |
| sw_rsp_vpn | output | VPN_W | Page number of the entry |
| sw_rsp_pfn | output | PFN_W | Physical page number of the entry |
| sw_rsp_nomatch | output | 1 | Probe found no entry |

## Verification
Single requests on each side are measured for latency. These separate a hit, a refilled miss and a joint-TLB miss, and show whether a refill actually took place. Paired requests that hit together and miss together separate true parallel lookup from serialised access, and they check that the data side wins the search port. A scripted series of hits and misses on a full data micro-TLB predicts exactly which page is evicted, and it tells true least-recently-used order apart from fill order. A joint-TLB write placed between repeated requests tells a flushed micro-TLB apart from one that kept stale entries, through the latency and the returned page number.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the dual micro-TLB translator.
package tlb_pkg;
    // Software command codes on sw_op.
    typedef enum logic [1:0] {
        SW_READ  = 2'd0,
        SW_WRITE = 2'd1,
        SW_PROBE = 2'd2,
        SW_NONE  = 2'd3
    } sw_op_e;

    // Per-side request state.
    typedef enum logic {
        SIDE_IDLE = 1'b0,
        SIDE_WAIT = 1'b1
    } side_st_e;
endpackage

// File: rtl/tlb_micro.sv
`timescale 1ns/1ps
// Small fully associative micro-TLB with least-recently-used replacement.
// Each entry carries an age from 0 (newest) to N-1 (oldest), and the ages
// always form a permutation. A hit or a refill makes the touched entry age 0.
// Assumes lookups and refills never hit the same cycle; if they do, the refill wins.
// A flush clears all valid bits and drops any refill in the same cycle.
module tlb_micro #(
    parameter int N     = 4,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_en,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             flush
);
    localparam int AW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     val_q;
    logic [VPN_W-1:0] vpn_q [N];
    logic [PFN_W-1:0] pfn_q [N];
    logic [AW-1:0]    age_q [N];

    logic [N-1:0]  match;
    logic [AW-1:0] hit_idx;
    logic [AW-1:0] victim;
    logic          have_free;
    logic          upd;
    logic [AW-1:0] uidx;

    // Tag compare for every entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = val_q[g] && (vpn_q[g] == lk_vpn);
    end

    // Hit detection and selection of the matching entry (lowest index).
    always_comb begin
        lk_hit  = 1'b0;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit  = 1'b1;
                hit_idx = AW'(i);
            end
        end
        lk_pfn = pfn_q[hit_idx];
    end

    // Victim choice: lowest invalid slot first, otherwise the oldest entry.
    always_comb begin
        have_free = 1'b0;
        victim    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (age_q[i] == AW'(N - 1)) victim = AW'(i);
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (!val_q[i]) begin
                have_free = 1'b1;
                victim    = AW'(i);
            end
        end
    end

    // Which entry gets marked most recently used this cycle.
    always_comb begin
        upd  = fill_en || (lk_en && lk_hit);
        uidx = fill_en ? victim : hit_idx;
    end

    // Entry storage, refill and age update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            for (int i = 0; i < N; i++) begin
                vpn_q[i] <= '0;
                pfn_q[i] <= '0;
                age_q[i] <= AW'(i);
            end
        end else if (flush) begin
            val_q <= '0;
        end else begin
            if (fill_en) begin
                val_q[victim] <= 1'b1;
                vpn_q[victim] <= fill_vpn;
                pfn_q[victim] <= fill_pfn;
            end
            if (upd) begin
                for (int i = 0; i < N; i++) begin
                    if (AW'(i) == uidx)
                        age_q[i] <= '0;
                    else if (age_q[i] < age_q[uidx])
                        age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tlb_joint.sv
`timescale 1ns/1ps
// Joint TLB: N entries with one translation search port, one probe port,
// one indexed read port and one indexed write port.
// Searches return the lowest matching valid index. Software is expected
// to keep page numbers unique. A write is visible from the next cycle.
module tlb_joint #(
    parameter int N     = 64,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VPN_W-1:0]     srch_vpn,
    output logic                 srch_hit,
    output logic [PFN_W-1:0]     srch_pfn,
    input  logic [VPN_W-1:0]     prb_vpn,
    output logic                 prb_hit,
    output logic [$clog2(N)-1:0] prb_idx,
    output logic [PFN_W-1:0]     prb_pfn,
    input  logic [$clog2(N)-1:0] rd_idx,
    output logic                 rd_val,
    output logic [VPN_W-1:0]     rd_vpn,
    output logic [PFN_W-1:0]     rd_pfn,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic                 wr_val,
    input  logic [VPN_W-1:0]     wr_vpn,
    input  logic [PFN_W-1:0]     wr_pfn
);
    localparam int IW = $clog2(N);

    logic [N-1:0]     val_q;
    logic [VPN_W-1:0] vpn_q [N];
    logic [PFN_W-1:0] pfn_q [N];

    logic [N-1:0]  s_match;
    logic [N-1:0]  p_match;
    logic [IW-1:0] s_idx;

    // Compare both search ports against every entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign s_match[g] = val_q[g] && (vpn_q[g] == srch_vpn);
        assign p_match[g] = val_q[g] && (vpn_q[g] == prb_vpn);
    end

    // Lowest-index priority encode for both ports.
    always_comb begin
        srch_hit = 1'b0;
        s_idx    = '0;
        prb_hit  = 1'b0;
        prb_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (s_match[i]) begin
                srch_hit = 1'b1;
                s_idx    = IW'(i);
            end
            if (p_match[i]) begin
                prb_hit = 1'b1;
                prb_idx = IW'(i);
            end
        end
        srch_pfn = srch_hit ? pfn_q[s_idx] : '0;
        prb_pfn  = prb_hit ? pfn_q[prb_idx] : '0;
    end

    // Indexed read port.
    always_comb begin
        rd_val = val_q[rd_idx];
        rd_vpn = vpn_q[rd_idx];
        rd_pfn = pfn_q[rd_idx];
    end

    // Entry storage and software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            for (int i = 0; i < N; i++) begin
                vpn_q[i] <= '0;
                pfn_q[i] <= '0;
            end
        end else if (wr_en) begin
            val_q[wr_idx] <= wr_val;
            vpn_q[wr_idx] <= wr_vpn;
            pfn_q[wr_idx] <= wr_pfn;
        end
    end
endmodule

// File: rtl/tlb_side.sv
`timescale 1ns/1ps
// Request control for one translation side.
// When idle it accepts a request, looks it up in its micro-TLB, and answers
// next cycle on a hit. On a miss it holds the page number and waits with
// ready low until it is granted the joint-TLB search port. It answers one
// cycle after the grant, and the grant cycle also drives the micro-TLB refill.
module tlb_side
    import tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             req_ready,
    output logic             lk_en,
    input  logic             u_hit,
    input  logic [PFN_W-1:0] u_pfn,
    output logic             waiting,
    output logic [VPN_W-1:0] held_vpn,
    input  logic             grant,
    input  logic             j_hit,
    input  logic [PFN_W-1:0] j_pfn,
    output logic             fill_en,
    output logic             rsp_valid,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic             rsp_fault
);
    side_st_e st_q;
    logic     accept;
    logic     served;

    // Handshake and grant decode.
    always_comb begin
        req_ready = (st_q == SIDE_IDLE);
        accept    = req_valid && req_ready;
        lk_en     = accept;
        waiting   = (st_q == SIDE_WAIT);
        served    = waiting && grant;
        fill_en   = served && j_hit;
    end

    // State, held page number and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= SIDE_IDLE;
            held_vpn  <= '0;
            rsp_valid <= 1'b0;
            rsp_pfn   <= '0;
            rsp_fault <= 1'b0;
        end else begin
            if (accept) held_vpn <= req_vpn;
            if (accept && !u_hit)
                st_q <= SIDE_WAIT;
            else if (served)
                st_q <= SIDE_IDLE;
            rsp_valid <= (accept && u_hit) || served;
            rsp_fault <= served && !j_hit;
            if (accept && u_hit)
                rsp_pfn <= u_pfn;
            else if (fill_en)
                rsp_pfn <= j_pfn;
            else
                rsp_pfn <= '0;
        end
    end
endmodule

// File: rtl/dual_tlb.sv
`timescale 1ns/1ps
// Dual micro-TLB translator: instruction and data sides each have a
// micro-TLB, and both share one joint TLB. The joint-TLB search port goes
// to the data side first. Software read, write and probe act on the joint
// TLB; every write flushes both micro-TLBs.
module dual_tlb
    import tlb_pkg::*;
#(
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int MICRO_N = 4,
    parameter int JOINT_N = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       i_req_valid,
    input  logic [VPN_W-1:0]           i_req_vpn,
    output logic                       i_req_ready,
    output logic                       i_rsp_valid,
    output logic [PFN_W-1:0]           i_rsp_pfn,
    output logic                       i_rsp_fault,
    input  logic                       d_req_valid,
    input  logic [VPN_W-1:0]           d_req_vpn,
    output logic                       d_req_ready,
    output logic                       d_rsp_valid,
    output logic [PFN_W-1:0]           d_rsp_pfn,
    output logic                       d_rsp_fault,
    input  logic                       sw_valid,
    input  logic [1:0]                 sw_op,
    input  logic [$clog2(JOINT_N)-1:0] sw_index,
    input  logic [VPN_W-1:0]           sw_vpn,
    input  logic [PFN_W-1:0]           sw_pfn,
    input  logic                       sw_entry_valid,
    output logic                       sw_rsp_valid,
    output logic                       sw_rsp_entry_valid,
    output logic [$clog2(JOINT_N)-1:0] sw_rsp_index,
    output logic [VPN_W-1:0]           sw_rsp_vpn,
    output logic [PFN_W-1:0]           sw_rsp_pfn,
    output logic                       sw_rsp_nomatch
);
    localparam int JIW = $clog2(JOINT_N);

    logic             i_lk_en, d_lk_en;
    logic             i_u_hit, d_u_hit;
    logic [PFN_W-1:0] i_u_pfn, d_u_pfn;
    logic             i_wait, d_wait;
    logic [VPN_W-1:0] i_held, d_held;
    logic             i_grant, d_grant;
    logic             i_fill, d_fill;
    logic [VPN_W-1:0] srch_vpn;
    logic             srch_hit;
    logic [PFN_W-1:0] srch_pfn;
    logic             prb_hit;
    logic [JIW-1:0]   prb_idx;
    logic [PFN_W-1:0] prb_pfn;
    logic             rd_val;
    logic [VPN_W-1:0] rd_vpn;
    logic [PFN_W-1:0] rd_pfn;
    logic             is_rd, is_wr, is_prb;

    // Software command decode.
    always_comb begin
        is_rd  = sw_valid && (sw_op_e'(sw_op) == SW_READ);
        is_wr  = sw_valid && (sw_op_e'(sw_op) == SW_WRITE);
        is_prb = sw_valid && (sw_op_e'(sw_op) == SW_PROBE);
    end

    // Joint-TLB search port arbitration: the data side has priority.
    always_comb begin
        d_grant  = d_wait;
        i_grant  = i_wait && !d_wait;
        srch_vpn = d_wait ? d_held : i_held;
    end

    tlb_micro #(.N(MICRO_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_imicro (
        .clk(clk), .rst_n(rst_n),
        .lk_en(i_lk_en), .lk_vpn(i_req_vpn), .lk_hit(i_u_hit), .lk_pfn(i_u_pfn),
        .fill_en(i_fill), .fill_vpn(i_held), .fill_pfn(srch_pfn), .flush(is_wr)
    );

    tlb_micro #(.N(MICRO_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_dmicro (
        .clk(clk), .rst_n(rst_n),
        .lk_en(d_lk_en), .lk_vpn(d_req_vpn), .lk_hit(d_u_hit), .lk_pfn(d_u_pfn),
        .fill_en(d_fill), .fill_vpn(d_held), .fill_pfn(srch_pfn), .flush(is_wr)
    );

    tlb_side #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_iside (
        .clk(clk), .rst_n(rst_n),
        .req_valid(i_req_valid), .req_vpn(i_req_vpn), .req_ready(i_req_ready),
        .lk_en(i_lk_en), .u_hit(i_u_hit), .u_pfn(i_u_pfn),
        .waiting(i_wait), .held_vpn(i_held), .grant(i_grant),
        .j_hit(srch_hit), .j_pfn(srch_pfn), .fill_en(i_fill),
        .rsp_valid(i_rsp_valid), .rsp_pfn(i_rsp_pfn), .rsp_fault(i_rsp_fault)
    );

    tlb_side #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_dside (
        .clk(clk), .rst_n(rst_n),
        .req_valid(d_req_valid), .req_vpn(d_req_vpn), .req_ready(d_req_ready),
        .lk_en(d_lk_en), .u_hit(d_u_hit), .u_pfn(d_u_pfn),
        .waiting(d_wait), .held_vpn(d_held), .grant(d_grant),
        .j_hit(srch_hit), .j_pfn(srch_pfn), .fill_en(d_fill),
        .rsp_valid(d_rsp_valid), .rsp_pfn(d_rsp_pfn), .rsp_fault(d_rsp_fault)
    );

    tlb_joint #(.N(JOINT_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_joint (
        .clk(clk), .rst_n(rst_n),
        .srch_vpn(srch_vpn), .srch_hit(srch_hit), .srch_pfn(srch_pfn),
        .prb_vpn(sw_vpn), .prb_hit(prb_hit), .prb_idx(prb_idx), .prb_pfn(prb_pfn),
        .rd_idx(sw_index), .rd_val(rd_val), .rd_vpn(rd_vpn), .rd_pfn(rd_pfn),
        .wr_en(is_wr), .wr_idx(sw_index), .wr_val(sw_entry_valid),
        .wr_vpn(sw_vpn), .wr_pfn(sw_pfn)
    );

    // Registered software response for read and probe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_rsp_valid       <= 1'b0;
            sw_rsp_entry_valid <= 1'b0;
            sw_rsp_index       <= '0;
            sw_rsp_vpn         <= '0;
            sw_rsp_pfn         <= '0;
            sw_rsp_nomatch     <= 1'b0;
        end else begin
            sw_rsp_valid <= is_rd || is_prb;
            if (is_rd) begin
                sw_rsp_entry_valid <= rd_val;
                sw_rsp_index       <= sw_index;
                sw_rsp_vpn         <= rd_vpn;
                sw_rsp_pfn         <= rd_pfn;
                sw_rsp_nomatch     <= 1'b0;
            end else if (is_prb) begin
                sw_rsp_entry_valid <= prb_hit;
                sw_rsp_index       <= prb_hit ? prb_idx : '0;
                sw_rsp_vpn         <= prb_hit ? sw_vpn : '0;
                sw_rsp_pfn         <= prb_pfn;
                sw_rsp_nomatch     <= !prb_hit;
            end else begin
                sw_rsp_entry_valid <= 1'b0;
                sw_rsp_index       <= '0;
                sw_rsp_vpn         <= '0;
                sw_rsp_pfn         <= '0;
                sw_rsp_nomatch     <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_tlb_sva.sv
`timescale 1ns/1ps
// Timing and encoding properties of dual_tlb, observed at its ports.
module dual_tlb_sva #(
    parameter int PFN_W   = 20,
    parameter int JOINT_N = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       i_req_valid,
    input logic                       i_req_ready,
    input logic                       i_rsp_valid,
    input logic [PFN_W-1:0]           i_rsp_pfn,
    input logic                       i_rsp_fault,
    input logic                       d_req_valid,
    input logic                       d_req_ready,
    input logic                       d_rsp_valid,
    input logic [PFN_W-1:0]           d_rsp_pfn,
    input logic                       d_rsp_fault,
    input logic                       sw_valid,
    input logic [1:0]                 sw_op,
    input logic                       sw_rsp_valid,
    input logic [$clog2(JOINT_N)-1:0] sw_rsp_index,
    input logic                       sw_rsp_nomatch
);
    AST_I_ACCEPT_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req_valid && i_req_ready) |=> (i_rsp_valid || !i_req_ready)); // R3
    AST_D_ACCEPT_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req_valid && d_req_ready) |=> (d_rsp_valid || !d_req_ready)); // R3
    AST_D_STALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !d_req_ready |=> d_req_ready); // R5
    AST_I_STALL_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_req_ready && $past(!i_req_ready)) |=> i_req_ready); // R6
    AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_req_ready && !d_req_ready) |=> !i_req_ready); // R6
    AST_D_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        d_rsp_valid |-> d_req_ready); // R11
    AST_I_FAULT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        i_rsp_fault |-> (i_rsp_valid && i_rsp_pfn == '0)); // R10
    AST_D_FAULT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        d_rsp_fault |-> (d_rsp_valid && d_rsp_pfn == '0)); // R10
    AST_SW_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && (sw_op == 2'd0 || sw_op == 2'd2)) |=> sw_rsp_valid); // R7
    AST_SW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_valid && (sw_op == 2'd0 || sw_op == 2'd2)) |=> !sw_rsp_valid); // R7
    AST_NOMATCH_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rsp_nomatch |-> (sw_rsp_valid && sw_rsp_index == '0)); // R8
endmodule

bind dual_tlb dual_tlb_sva #(.PFN_W(PFN_W), .JOINT_N(JOINT_N)) u_sva (.*);

// File: tb/dual_tlb_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: drivers queue the expected responses, and a monitor
// compares them as the responses appear. Latency and ready are checked inline.
module dual_tlb_tb;
    localparam int VW = 20;
    localparam int PW = 20;
    localparam int JN = 64;
    localparam int IW = $clog2(JN);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          i_req_valid, d_req_valid;
    logic [VW-1:0] i_req_vpn, d_req_vpn;
    logic          i_req_ready, d_req_ready;
    logic          i_rsp_valid, d_rsp_valid;
    logic [PW-1:0] i_rsp_pfn, d_rsp_pfn;
    logic          i_rsp_fault, d_rsp_fault;
    logic          sw_valid;
    logic [1:0]    sw_op;
    logic [IW-1:0] sw_index;
    logic [VW-1:0] sw_vpn;
    logic [PW-1:0] sw_pfn;
    logic          sw_entry_valid;
    logic          sw_rsp_valid, sw_rsp_entry_valid, sw_rsp_nomatch;
    logic [IW-1:0] sw_rsp_index;
    logic [VW-1:0] sw_rsp_vpn;
    logic [PW-1:0] sw_rsp_pfn;

    dual_tlb #(.VPN_W(VW), .PFN_W(PW), .MICRO_N(4), .JOINT_N(JN)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .i_req_valid(i_req_valid), .i_req_vpn(i_req_vpn), .i_req_ready(i_req_ready),
        .i_rsp_valid(i_rsp_valid), .i_rsp_pfn(i_rsp_pfn), .i_rsp_fault(i_rsp_fault),
        .d_req_valid(d_req_valid), .d_req_vpn(d_req_vpn), .d_req_ready(d_req_ready),
        .d_rsp_valid(d_rsp_valid), .d_rsp_pfn(d_rsp_pfn), .d_rsp_fault(d_rsp_fault),
        .sw_valid(sw_valid), .sw_op(sw_op), .sw_index(sw_index), .sw_vpn(sw_vpn),
        .sw_pfn(sw_pfn), .sw_entry_valid(sw_entry_valid),
        .sw_rsp_valid(sw_rsp_valid), .sw_rsp_entry_valid(sw_rsp_entry_valid),
        .sw_rsp_index(sw_rsp_index), .sw_rsp_vpn(sw_rsp_vpn), .sw_rsp_pfn(sw_rsp_pfn),
        .sw_rsp_nomatch(sw_rsp_nomatch)
    );

    int total = 0;
    int bad   = 0;

    // Reference joint-TLB contents, maintained from the bench's own writes.
    logic          m_val [JN];
    logic [VW-1:0] m_vpn [JN];
    logic [PW-1:0] m_pfn [JN];

    // Expected responses {fault, pfn} per side.
    logic [PW:0] iq[$];
    logic [PW:0] dq[$];

    task automatic chk(input bit ok, input string req, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    function automatic logic [PW:0] model_xlate(input logic [VW-1:0] vpn);
        for (int k = 0; k < JN; k++)
            if (m_val[k] && m_vpn[k] == vpn) return {1'b0, m_pfn[k]};
        return {1'b1, {PW{1'b0}}};
    endfunction

    // Monitor: compare every response with the head of its queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (i_rsp_valid) begin
                if (iq.size() == 0) chk(1'b0, "R3", "instr response with nothing expected");
                else begin
                    logic [PW:0] e;
                    e = iq.pop_front();
                    chk({i_rsp_fault, i_rsp_pfn} == e, e[PW] ? "R10" : "R3",
                        $sformatf("instr rsp act=%h exp=%h", {i_rsp_fault, i_rsp_pfn}, e));
                end
            end
            if (d_rsp_valid) begin
                if (dq.size() == 0) chk(1'b0, "R3", "data response with nothing expected");
                else begin
                    logic [PW:0] e;
                    e = dq.pop_front();
                    chk({d_rsp_fault, d_rsp_pfn} == e, e[PW] ? "R10" : "R3",
                        $sformatf("data rsp act=%h exp=%h", {d_rsp_fault, d_rsp_pfn}, e));
                end
            end
        end
    end

    task automatic sw_cmd(input logic [1:0] op, input logic [IW-1:0] idx,
                          input logic [VW-1:0] vpn, input logic [PW-1:0] pfn, input logic ev);
        @(negedge clk);
        sw_valid = 1'b1; sw_op = op; sw_index = idx; sw_vpn = vpn;
        sw_pfn = pfn; sw_entry_valid = ev;
        @(negedge clk);
        sw_valid = 1'b0;
    endtask

    task automatic jwrite(input int idx, input logic [VW-1:0] vpn, input logic [PW-1:0] pfn,
                          input logic ev);
        sw_cmd(2'd1, IW'(idx), vpn, pfn, ev);
        m_val[idx] = ev; m_vpn[idx] = vpn; m_pfn[idx] = pfn;
        chk(!sw_rsp_valid, "R7", $sformatf("write response act=%b exp=0", sw_rsp_valid));
    endtask

    // One request on one side (0 instr, 1 data); returns latency in cycles.
    task automatic xl_one(input bit side, input logic [VW-1:0] vpn, output int lat);
        @(negedge clk);
        if (side) begin dq.push_back(model_xlate(vpn)); d_req_valid = 1'b1; d_req_vpn = vpn; end
        else      begin iq.push_back(model_xlate(vpn)); i_req_valid = 1'b1; i_req_vpn = vpn; end
        @(negedge clk);
        i_req_valid = 1'b0; d_req_valid = 1'b0;
        lat = 1;
        while (!(side ? d_rsp_valid : i_rsp_valid) && lat < 10) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Simultaneous requests on both sides with ready samples.
    task automatic xl_pair(input logic [VW-1:0] ivpn, input logic [VW-1:0] dvpn,
                           output int li, output int ld,
                           output logic ri1, output logic rd1, output logic ri2);
        int n;
        @(negedge clk);
        iq.push_back(model_xlate(ivpn)); dq.push_back(model_xlate(dvpn));
        i_req_valid = 1'b1; i_req_vpn = ivpn; d_req_valid = 1'b1; d_req_vpn = dvpn;
        @(negedge clk);
        i_req_valid = 1'b0; d_req_valid = 1'b0;
        n = 1; li = 0; ld = 0; ri1 = i_req_ready; rd1 = d_req_ready; ri2 = 1'b1;
        while ((li == 0 || ld == 0) && n < 10) begin
            if (i_rsp_valid && li == 0) li = n;
            if (d_rsp_valid && ld == 0) ld = n;
            if (n == 2) ri2 = i_req_ready;
            if (li == 0 || ld == 0) begin
                @(negedge clk);
                n++;
            end
        end
    endtask

    // Watchdog.
    initial begin
        #(5 * 100000);
        total++; bad++;
        $display("FAIL watchdog: act=expired exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat, li, ld;
        logic ri1, rd1, ri2;
        for (int k = 0; k < JN; k++) begin m_val[k] = 1'b0; m_vpn[k] = '0; m_pfn[k] = '0; end
        rst_n = 1'b0; i_req_valid = 1'b0; d_req_valid = 1'b0; i_req_vpn = '0; d_req_vpn = '0;
        sw_valid = 1'b0; sw_op = 2'd3; sw_index = '0; sw_vpn = '0; sw_pfn = '0; sw_entry_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(i_req_ready && d_req_ready, "R1",
            $sformatf("ready after reset act=%b%b exp=11", i_req_ready, d_req_ready));
        chk(!i_rsp_valid && !d_rsp_valid && !sw_rsp_valid, "R1",
            $sformatf("valids after reset act=%b%b%b exp=000", i_rsp_valid, d_rsp_valid, sw_rsp_valid));
        rst_n = 1'b1;

        // R1: empty joint TLB after reset.
        sw_cmd(2'd2, '0, '0, '0, 1'b0);
        chk(sw_rsp_valid && sw_rsp_nomatch, "R1",
            $sformatf("probe after reset nomatch act=%b exp=1", sw_rsp_nomatch));

        for (int k = 0; k < 10; k++) jwrite(k, VW'(32'h100 + k), PW'(32'hA000 + k), 1'b1);
        jwrite(30, 20'h107, 20'hD000, 1'b1);

        // R7: read of written and empty slots.
        sw_cmd(2'd0, IW'(3), '0, '0, 1'b0);
        chk(sw_rsp_valid && sw_rsp_entry_valid && sw_rsp_vpn == 20'h103 && sw_rsp_pfn == 20'hA003, "R7",
            $sformatf("read idx3 act=%b/%h/%h exp=1/00103/0a003", sw_rsp_entry_valid, sw_rsp_vpn, sw_rsp_pfn));
        sw_cmd(2'd0, IW'(40), '0, '0, 1'b0);
        chk(sw_rsp_valid && !sw_rsp_entry_valid, "R7",
            $sformatf("read idx40 valid act=%b exp=0", sw_rsp_entry_valid));
        sw_cmd(2'd3, IW'(3), 20'h103, '0, 1'b0);
        chk(!sw_rsp_valid, "R7", $sformatf("no-action response act=%b exp=0", sw_rsp_valid));

        // R8: probe hit, lowest index on duplicate, and miss.
        sw_cmd(2'd2, '0, 20'h105, '0, 1'b0);
        chk(!sw_rsp_nomatch && sw_rsp_index == IW'(5), "R8",
            $sformatf("probe 105 act=%0d/%b exp=5/0", sw_rsp_index, sw_rsp_nomatch));
        sw_cmd(2'd2, '0, 20'h107, '0, 1'b0);
        chk(!sw_rsp_nomatch && sw_rsp_index == IW'(7), "R8",
            $sformatf("probe dup act=%0d exp=7", sw_rsp_index));
        sw_cmd(2'd2, '0, 20'h999, '0, 1'b0);
        chk(sw_rsp_nomatch && sw_rsp_index == '0, "R8",
            $sformatf("probe miss act=%b/%0d exp=1/0", sw_rsp_nomatch, sw_rsp_index));

        // R5 then R3: miss then hit on data side.
        xl_one(1'b1, 20'h101, lat);
        chk(lat == 2, "R5", $sformatf("data miss latency act=%0d exp=2", lat));
        xl_one(1'b1, 20'h101, lat);
        chk(lat == 1, "R3", $sformatf("data hit latency act=%0d exp=1", lat));
        // R2: instruction side has its own micro-TLB.
        xl_one(1'b0, 20'h101, lat);
        chk(lat == 2, "R2", $sformatf("instr first access latency act=%0d exp=2", lat));

        // R6 and R11: simultaneous misses.
        xl_pair(20'h102, 20'h103, li, ld, ri1, rd1, ri2);
        chk(ld == 2, "R6", $sformatf("data latency on dual miss act=%0d exp=2", ld));
        chk(li == 3, "R6", $sformatf("instr latency on dual miss act=%0d exp=3", li));
        chk(!ri1 && !rd1, "R11", $sformatf("ready while waiting act=%b%b exp=00", ri1, rd1));
        chk(!ri2, "R11", $sformatf("instr ready in second wait cycle act=%b exp=0", ri2));
        chk(i_req_ready && d_req_ready, "R11",
            $sformatf("ready after both answers act=%b%b exp=11", i_req_ready, d_req_ready));

        // R2: simultaneous hits.
        xl_pair(20'h102, 20'h103, li, ld, ri1, rd1, ri2);
        chk(li == 1 && ld == 1, "R2", $sformatf("dual hit latency act=%0d/%0d exp=1/1", li, ld));

        // R10: joint miss, no refill.
        xl_one(1'b1, 20'h777, lat);
        chk(lat == 2, "R10", $sformatf("joint miss latency act=%0d exp=2", lat));
        xl_one(1'b1, 20'h777, lat);
        chk(lat == 2, "R10", $sformatf("repeat joint miss latency act=%0d exp=2", lat));

        // R4: replacement order on the data micro-TLB.
        xl_one(1'b1, 20'h104, lat);
        xl_one(1'b1, 20'h105, lat);
        xl_one(1'b1, 20'h101, lat);
        chk(lat == 1, "R4", $sformatf("hit on 101 act=%0d exp=1", lat));
        xl_one(1'b1, 20'h106, lat);
        chk(lat == 2, "R4", $sformatf("fill 106 act=%0d exp=2", lat));
        xl_one(1'b1, 20'h101, lat);
        chk(lat == 1, "R4", $sformatf("101 kept act=%0d exp=1", lat));
        xl_one(1'b1, 20'h103, lat);
        chk(lat == 2, "R4", $sformatf("103 evicted act=%0d exp=2", lat));
        xl_one(1'b1, 20'h105, lat);
        chk(lat == 1, "R4", $sformatf("105 kept act=%0d exp=1", lat));
        xl_one(1'b1, 20'h104, lat);
        chk(lat == 2, "R4", $sformatf("104 evicted act=%0d exp=2", lat));

        // R9: a joint write flushes both micro-TLBs; the new mapping is used.
        jwrite(1, 20'h101, 20'hC001, 1'b1);
        xl_one(1'b1, 20'h101, lat);
        chk(lat == 2, "R9", $sformatf("data after write act=%0d exp=2", lat));
        xl_one(1'b0, 20'h102, lat);
        chk(lat == 2, "R9", $sformatf("instr after write act=%0d exp=2", lat));

        repeat (3) @(negedge clk);
        chk(iq.size() == 0 && dq.size() == 0, "R3",
            $sformatf("pending expected act=%0d/%0d exp=0/0", iq.size(), dq.size()));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule